// File: doc/BRIEF.md
# Quadratic Residue Keystream Cipher

This block encrypts a serial bit stream by XOR with a keystream drawn from repeated modular squaring. After a start request, a configured seed is squared modulo a configured modulus. Each following result is squared again. From every result, a small number of low-order bits is kept and shifted out least significant bit first, one per accepted data bit.

The active operand width is chosen at start time, from 64 to 512 bits in steps of 64. Every squaring takes one cycle per active operand bit, so a narrower width gives a shorter squaring and a smaller modulus. The number of keystream bits kept per result follows the width. Asserting start again reloads the seed, which lets a receiver realign its keystream at a synchronisation marker. The serial input is stalled by a ready signal while no keystream bit is buffered.

Top module: `qrk_cipher`

## Requirements
- R1: Starting from the seed x0, each state is x(i+1) = x(i)^2 mod N. The keystream is taken from x1, x2, ... in order, and the seed itself contributes no keystream bits.
- R2: The number of bits kept per result depends on the width code k (active width W = 64*(k+1)) and equals floor(log2 W). For k = 0..7 this gives 6, 7, 7, 8, 8, 8, 8, 9.
- R3: The kept bits of one result are used least significant bit first. Each ciphertext bit is the accepted plaintext bit XOR the current keystream bit.
- R4: `dout_valid_o` is high in exactly the cycle after each accepted bit (`din_valid_i && din_ready_o` at a rising clock edge), and `dout_o` holds that bit's ciphertext in that cycle. Otherwise `dout_valid_o` is low.
- R5: `din_ready_o` is low while no keystream bit is buffered. A bit offered while ready is low is not accepted and produces no output. Idle cycles, with `din_valid_i` low, do not advance the keystream.
- R6: A one-cycle `start_i` pulse latches modulus, seed and width code. It discards any buffered keystream bits and restarts the sequence from the seed, so the next ciphertext uses the bits of x1 again. `din_ready_o` stays low for at least W cycles after the start.
- R7: The width code `cfg_wcode_i` selects W = 64*(k+1). The modulus must be below 2^W, and the seed must be below the modulus. Widths 64, 128, 192 and 512 each give the exact sequence of R1 and R2.
- R8: After reset, `din_ready_o` and `dout_valid_o` are low until a start has been given and the first result is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mod_i | input | 512 | Modulus N, latched on start |
| cfg_seed_i | input | 512 | Seed x0, latched on start |
| cfg_wcode_i | input | 3 | Width code k, W = 64*(k+1), latched on start |
| start_i | input | 1 | Start / resync pulse |
| din_i | input | 1 | Plaintext bit |
| din_valid_i | input | 1 | Plaintext bit offered |
| din_ready_o | output | 1 | A keystream bit is available |
| dout_o | output | 1 | Ciphertext bit |
| dout_valid_o | output | 1 | Ciphertext bit valid |

## Verification
The assertions assume that every operand fed to the squarer is already reduced: the modulus fits in W bits and is nonzero, and the seed is below the modulus. The bench meets these conditions by choosing each modulus with its top bits clear above W and each seed with a smaller leading digit than its modulus. The bench also assumes that `start_i` is a single-cycle pulse given while `din_valid_i` is low, and it drives it that way. Expected ciphertext comes from a wide-integer square-and-remainder model in the bench, with the kept-bit counts taken from its own width table.

// File: rtl/qrk_pkg.sv
package qrk_pkg;
  // floor(log2(v)), v > 0
  function automatic int unsigned flog2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((v >> i) != 0) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/qrk_modsq.sv
// Bit-serial interleaved modular squarer: one operand bit per cycle, MSB first.
module qrk_modsq #(
  parameter int MAX_W  = 512,
  parameter int STEP_W = 64,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ld_i,
  input  logic [MAX_W-1:0]  mod_i,
  input  logic [CODE_W-1:0] wcode_i,
  input  logic              go_i,
  input  logic [MAX_W-1:0]  op_i,
  output logic              done_o,
  output logic [MAX_W-1:0]  res_o
);
  localparam int EW = MAX_W + 2;

  logic [MAX_W-1:0]  mod_q, mcand_q, mplier_q, acc_q;
  logic [CODE_W-1:0] wcode_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;

  logic [CODE_W-1:0] wsel;
  logic [CNT_W-1:0]  wlen;
  logic [MAX_W-1:0]  op_al, mod_sel;
  logic [EW-1:0]     mext, t0, t1, t2;

  assign wsel    = cfg_ld_i ? wcode_i : wcode_q;
  assign mod_sel = cfg_ld_i ? mod_i : mod_q;
  assign wlen    = CNT_W'((32'(wsel) + 32'd1) * 32'(STEP_W));
  // left-align the active operand so its MSB sits at the top
  assign op_al   = op_i << (32'(MAX_W) - 32'(wlen));

  always_comb begin
    mext = {2'b00, mod_q};
    t0 = {1'b0, acc_q, 1'b0} + (mplier_q[MAX_W-1] ? {2'b00, mcand_q} : '0);
    t1 = (t0 >= mext) ? t0 - mext : t0;
    t2 = (t1 >= mext) ? t1 - mext : t1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_q    <= '0;
      wcode_q  <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (cfg_ld_i) begin
        mod_q   <= mod_i;
        wcode_q <= wcode_i;
      end
      if (go_i) begin
        mcand_q  <= op_i;
        mplier_q <= op_al;
        acc_q    <= '0;
        cnt_q    <= wlen;
        busy_q   <= 1'b1;
        done_q   <= 1'b0;
      end else if (busy_q) begin
        acc_q    <= t2[MAX_W-1:0];
        mplier_q <= mplier_q << 1;
        cnt_q    <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        done_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = acc_q;

  // R7: operands entering the squarer are reduced and the modulus fits the width
  a_r7_operand_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (op_i < mod_sel));
  a_r7_mod_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ld_i |-> ((mod_i != '0) && ((mod_i >> wlen) == '0)));
  // R1: partial result stays reduced throughout the iteration
  a_r1_acc_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (acc_q < mod_q));
  a_r1_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/qrk_keybuf.sv
// Holds the kept bits of one result and hands them out LSB first.
module qrk_keybuf #(
  parameter int MAX_BITS = 9,
  parameter int BCNT_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [BCNT_W-1:0]   n_i,
  input  logic                take_i,
  output logic                bit_o,
  output logic                avail_o
);
  logic [MAX_BITS-1:0] sh_q;
  logic [BCNT_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= n_i;
    end else if (take_i) begin
      sh_q  <= sh_q >> 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bit_o   = sh_q[0];
  assign avail_o = (cnt_q != '0);

  // R5: bits are only consumed while the buffer holds some
  a_r5_take_nonempty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (cnt_q != '0));
  // R2: a refill only happens into an empty buffer, with a legal count
  a_r2_load_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> ((cnt_q == '0) && (n_i != '0) && (32'(n_i) <= MAX_BITS)));
endmodule

// File: rtl/qrk_cipher.sv
module qrk_cipher #(
  parameter int MAX_W  = 512,
  parameter int STEP_W = 64
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [MAX_W-1:0]                      cfg_mod_i,
  input  logic [MAX_W-1:0]                      cfg_seed_i,
  input  logic [$clog2(MAX_W/STEP_W)-1:0]       cfg_wcode_i,
  input  logic                                  start_i,
  input  logic                                  din_i,
  input  logic                                  din_valid_i,
  output logic                                  din_ready_o,
  output logic                                  dout_o,
  output logic                                  dout_valid_o
);
  import qrk_pkg::*;

  localparam int NUM_W    = MAX_W / STEP_W;
  localparam int CODE_W   = $clog2(NUM_W);
  localparam int CNT_W    = $clog2(MAX_W + 1);
  localparam int MAX_BITS = int'(flog2(MAX_W));
  localparam int BCNT_W   = $clog2(MAX_BITS + 1);

  logic [BCNT_W-1:0] nbits_lut [NUM_W];
  for (genvar g = 0; g < NUM_W; g++) begin : g_nbits
    assign nbits_lut[g] = BCNT_W'(flog2(STEP_W * (g + 1)));
  end

  logic [BCNT_W-1:0] nbits_q;
  logic              pend_q, dout_q, dvalid_q;
  logic              sq_done, buf_avail, ks_bit, reload, sq_go, hs;
  logic [MAX_W-1:0]  sq_res, sq_op;

  assign reload = pend_q && !buf_avail && !start_i;
  assign sq_go  = start_i || reload;
  assign sq_op  = start_i ? cfg_seed_i : sq_res;
  assign hs     = din_valid_i && buf_avail;

  qrk_modsq #(
    .MAX_W (MAX_W),
    .STEP_W(STEP_W),
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_sq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_ld_i(start_i),
    .mod_i   (cfg_mod_i),
    .wcode_i (cfg_wcode_i),
    .go_i    (sq_go),
    .op_i    (sq_op),
    .done_o  (sq_done),
    .res_o   (sq_res)
  );

  qrk_keybuf #(
    .MAX_BITS(MAX_BITS),
    .BCNT_W  (BCNT_W)
  ) u_kb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(start_i),
    .load_i (reload),
    .data_i (sq_res[MAX_BITS-1:0]),
    .n_i    (nbits_q),
    .take_i (hs),
    .bit_o  (ks_bit),
    .avail_o(buf_avail)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nbits_q  <= '0;
      pend_q   <= 1'b0;
      dout_q   <= 1'b0;
      dvalid_q <= 1'b0;
    end else begin
      if (start_i) nbits_q <= nbits_lut[cfg_wcode_i];
      // result waiting in the squarer until the buffer drains
      if (start_i)      pend_q <= 1'b0;
      else if (sq_done) pend_q <= 1'b1;
      else if (reload)  pend_q <= 1'b0;
      dvalid_q <= hs;
      if (hs) dout_q <= din_i ^ ks_bit;
    end
  end

  assign din_ready_o  = buf_avail;
  assign dout_o       = dout_q;
  assign dout_valid_o = dvalid_q;

  // R4: one ciphertext strobe per accepted bit, one cycle later
  a_r4_dout_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_valid_i && din_ready_o) |=> dout_valid_o);
  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(din_valid_i && din_ready_o) |=> !dout_valid_o);
  // R5: offer without ready is not accepted
  a_r5_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (din_valid_i && !din_ready_o) |=> !dout_valid_o);
  // R6: start drops any buffered keystream
  a_r6_start_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !din_ready_o);
endmodule

// File: tb/tb_qrk_cipher.sv
module tb_qrk_cipher;
  localparam int MW = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [MW-1:0] cfg_mod_i = '0;
  logic [MW-1:0] cfg_seed_i = '0;
  logic [2:0]    cfg_wcode_i = '0;
  logic          start_i = 1'b0;
  logic          din_i = 1'b0;
  logic          din_valid_i = 1'b0;
  logic          din_ready_o, dout_o, dout_valid_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  qrk_cipher #(.MAX_W(MW), .STEP_W(64)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_mod_i(cfg_mod_i), .cfg_seed_i(cfg_seed_i),
    .cfg_wcode_i(cfg_wcode_i), .start_i(start_i), .din_i(din_i), .din_valid_i(din_valid_i),
    .din_ready_o(din_ready_o), .dout_o(dout_o), .dout_valid_o(dout_valid_o)
  );

  localparam logic [63:0] N64A = 64'd4294967291 * 64'd4294967279;
  localparam int NV = 4;
  localparam logic [2:0]   V_CODE [NV] = '{3'd0, 3'd0, 3'd1, 3'd1};
  localparam logic [127:0] V_MOD  [NV] = '{
    {64'd0, N64A},
    {64'd0, 64'hFFFF_FFFF_FFFF_FFC5},
    128'hE3C1_9A7B_5D2F_0817_6B4C_3A29_1F0E_D5A3,
    128'hB7F1_0042_9C3D_E55B_1A06_7729_C4E8_90F1};
  localparam logic [127:0] V_SEED [NV] = '{
    128'h0123_4567_89AB_CDEF,
    128'hDEAD_BEEF_0BAD_F00D,
    128'h1234_5678_9ABC_DEF0_0FED_CBA9_8765_4321,
    128'h0F00_1111_2222_3333_4444_5555_6666_7777};
  localparam int V_PAT [NV] = '{0, 1, 2, 3};
  localparam int V_LEN [NV] = '{24, 30, 21, 16};

  logic ks [0:255];

  function automatic int nb_of(input logic [2:0] k);
    case (k)
      3'd0: return 6;
      3'd1, 3'd2: return 7;
      3'd7: return 9;
      default: return 8;
    endcase
  endfunction

  function automatic logic pat_bit(input int p, input int i);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return i[0];
      default: return ((i * 7 + 3) % 5) < 2;
    endcase
  endfunction

  task automatic gen_ks(input logic [MW-1:0] n, input logic [MW-1:0] seed,
                        input logic [2:0] k, input int len);
    logic [2*MW-1:0] x;
    int pos = 0;
    x = {{MW{1'b0}}, seed};
    while (pos < len) begin
      x = (x * x) % {{MW{1'b0}}, n};
      for (int b = 0; b < nb_of(k) && pos < len; b++) begin
        ks[pos] = x[b];
        pos++;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [MW-1:0] n, input logic [MW-1:0] s, input logic [2:0] k);
    @(negedge clk_i);
    cfg_mod_i = n; cfg_seed_i = s; cfg_wcode_i = k; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic xfer(input logic p, input int gap, output logic o, output logic v);
    repeat (gap) @(negedge clk_i);
    din_i = p; din_valid_i = 1'b1;
    while (!din_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    v = dout_valid_o; o = dout_o;
    din_valid_i = 1'b0;
  endtask

  task automatic run_stream(input logic [2:0] k, input logic [MW-1:0] n, input logic [MW-1:0] s,
                            input int pat, input int len, input int gap, input string req);
    logic o, v;
    int bad = 0;
    gen_ks(n, s, k, len);
    do_start(n, s, k);
    for (int i = 0; i < len; i++) begin
      xfer(pat_bit(pat, i), (i % 4 == 3) ? gap : 0, o, v);
      checks++;
      if (!(v && o == (pat_bit(pat, i) ^ ks[i]))) begin
        errors++; bad++;
        $display("FAIL %s bit %0d actual=%0b/%0b expected=1/%0b", req, i, v, o,
                 pat_bit(pat, i) ^ ks[i]);
      end
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!finished) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000 && !finished) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin : main
    logic o, v;
    int cnt_bad;
    repeat (3) @(negedge clk_i);
    // R8: reset state
    check(din_ready_o == 1'b0, "R8 ready after reset", din_ready_o, 0);
    check(dout_valid_o == 1'b0, "R8 valid after reset", dout_valid_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(din_ready_o == 1'b0 && dout_valid_o == 1'b0, "R8 idle before start",
          din_ready_o, 0);

    // R1 R2 R3 R4 R7: vector table, several widths and plaintext patterns
    for (int t = 0; t < NV; t++)
      run_stream(V_CODE[t], {{(MW-128){1'b0}}, V_MOD[t]}, {{(MW-128){1'b0}}, V_SEED[t]},
                 V_PAT[t], V_LEN[t], t * 13, "R1/R3 vector");

    // R2 R7: width 192 gives 7 kept bits per result
    run_stream(3'd2, {64'd0, 128'hC0FF_EE00_1234_5678_9ABC_DEF0_1357_9BDF, 64'h2468_ACE0_1357_9BDB} >> 0,
               {64'd0, 128'h0BAD_CAFE_0000_1111_2222_3333_4444_5555, 64'h6666_7777_8888_9999},
               3, 20, 0, "R2 width192");
    // R2 R7: width 512 gives 9 kept bits per result
    run_stream(3'd7, {8{64'hF0E1_D2C3_B4A5_9687}}, {8{64'h0F1E_2D3C_4B5A_6978}},
               2, 18, 0, "R2 width512");

    // R5: long idle gaps between bits do not advance the keystream
    run_stream(3'd0, {{(MW-64){1'b0}}, N64A}, {{(MW-64){1'b0}}, 64'h0000_0000_0000_0003},
               3, 14, 90, "R5 idle gaps");

    // R6: resync mid-stream realigns to x1
    gen_ks({{(MW-64){1'b0}}, N64A}, {{(MW-64){1'b0}}, 64'h0123_4567_89AB_CDEF}, 3'd0, 16);
    do_start({{(MW-64){1'b0}}, N64A}, {{(MW-64){1'b0}}, 64'h0123_4567_89AB_CDEF}, 3'd0);
    for (int i = 0; i < 9; i++) xfer(pat_bit(2, i), 0, o, v);
    do_start({{(MW-64){1'b0}}, N64A}, {{(MW-64){1'b0}}, 64'h0123_4567_89AB_CDEF}, 3'd0);
    // R5 R6: ready low for W cycles after start, offered bits not taken
    din_i = 1'b1; din_valid_i = 1'b1;
    cnt_bad = 0;
    for (int c = 0; c < 60; c++) begin
      if (din_ready_o || dout_valid_o) cnt_bad++;
      @(negedge clk_i);
    end
    check(cnt_bad == 0, "R6 ready low after start", cnt_bad, 0);
    check(dout_valid_o == 1'b0, "R5 stalled offer gives no output", dout_valid_o, 0);
    din_valid_i = 1'b0;
    for (int i = 0; i < 16; i++) begin
      xfer(pat_bit(1, i), 0, o, v);
      check(v && o == (1'b1 ^ ks[i]), "R6 resync stream", int'(o), int'(1'b1 ^ ks[i]));
    end
    repeat (3) @(negedge clk_i);
    check(dout_valid_o == 1'b0, "R4 valid drops when idle", dout_valid_o, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule